// File: doc/BRIEF.md
# Dual-Mode Host Register Port

This block is an 8-bit asynchronous host bus slave that gives a processor access to eight control registers through a 3-bit address. A static mode pin picks one of two bus styles. With the pin low, the host uses separate active-low read and write strobes, and the block answers on a ready line that is held low while the access is in progress and released to complete it. With the pin high, the host uses an active-low data strobe and a read/write line that is high for reads, and the block answers by pulling a transfer-acknowledge line low once the access is complete.

The host strobes, chip select and direction line pass through a two-flop synchronizer before the core clock recognizes an access. The access then waits a programmable number of core cycles before it completes. That wait is 2, 3 or 4 cycles, selected by a speed field in register 7. Writes commit on the completing edge. Read data is captured on the same edge and is driven onto the bus only while the completed read strobe is still held. The handshake line is open-drain: `ack_pull_o` high means the block pulls the external line low, and low means the line is released to its pull-up. The data bus is a tri-state pad split into input, output and output-enable.

Top module: `regport_top`

## Requirements
- R1: After synchronous active-high reset, `ack_pull_o` and `dout_oe_o` are 0, and all eight registers read back 0x00, so the speed field is fast.
- R2: In mode 0, `ack_pull_o` is 1 from the moment chip select and a strobe are both low until the completing clock edge, and it is 0 after that edge.
- R3: In mode 1, `ack_pull_o` is 0 until the completing edge. It is then 1 while the strobe is held, and it returns to 0 after the third clock edge following strobe release.
- R4: Counting the first clock edge after strobe assertion as edge 1, the access completes at edge N+3. N is 2, 3 or 4 when register 7 bits [1:0] are 00, 01 or 10, and the value 11 behaves as 10.
- R5: With chip select (active low) high, strobe activity produces no handshake and changes no register.
- R6: A write stores `din_i` into the register at `addr_i` on the completing edge. A later read of that address returns the stored value, and no register changes outside a completing write.
- R7: `dout_oe_o` is 1 only during a completed read while the read strobe is still asserted, and it drops as soon as the strobe is released. In both modes this means it is only ever high after the handshake has signalled completion.
- R8: A strobe held after completion produces exactly one access. The handshake stays in its completed state until the strobe is released.
- R9: Direction decoding works as follows. In mode 0, `rd_ds_n_i` low means read and `wr_rw_i` low means write. In mode 1, `rd_ds_n_i` is the strobe and `wr_rw_i` high means read, low means write. Data written in one mode reads back in the other.
- R10: A write to the speed field changes the latency from the next access on. The write access itself completes with the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | Bus style: 0 separate strobes with ready, 1 data strobe with acknowledge |
| cs_n_i | input | 1 | Chip select, active low |
| addr_i | input | 3 | Register address |
| rd_ds_n_i | input | 1 | Mode 0 read strobe / mode 1 data strobe, active low |
| wr_rw_i | input | 1 | Mode 0 write strobe (active low) / mode 1 direction (1 read) |
| din_i | input | 8 | Data bus input from the pad |
| dout_o | output | 8 | Data bus output value |
| dout_oe_o | output | 1 | Data bus output enable |
| ack_pull_o | output | 1 | Handshake line pull-down (1 drives the open-drain line low) |

## Verification
If the wait counter or the latched speed goes wrong, the handshake edge moves by whole cycles on the very next access, and the per-cycle comparison flags it within that access. A corrupted register or a missed commit stays hidden until that address is read back, so every write is followed by a read, in the same mode or in the other one. A state machine that stops waiting for strobe release shows up as an early acknowledge drop in mode 1 or as a second handshake while the strobe is held. Output-enable errors show up in the same cycle as the strobe edge, because that path is combinational.

// File: rtl/regport_pkg.sv
package regport_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2
    } port_st_e;

    localparam logic [1:0] SPD_FAST = 2'b00;
    localparam logic [1:0] SPD_MED  = 2'b01;

    typedef struct packed {
        logic req;
        logic rd;
    } host_cmd_t;

    // Speed field to number of busy cycles before completion
    function automatic logic [2:0] speed_to_wait(input logic [1:0] spd);
        case (spd)
            SPD_FAST: return 3'd2;
            SPD_MED:  return 3'd3;
            default:  return 3'd4;
        endcase
    endfunction

    // Turn raw bus pins into a request and a direction for either bus style
    function automatic host_cmd_t decode_cmd(input logic mode, input logic cs_n,
                                             input logic strb_n, input logic aux);
        host_cmd_t c;
        if (mode) begin
            c.req = !cs_n && !strb_n;
            c.rd  = aux;
        end else begin
            c.req = !cs_n && (!strb_n || !aux);
            c.rd  = !strb_n;
        end
        return c;
    endfunction

endpackage

// File: rtl/regport_sync.sv
module regport_sync #(
    parameter int W = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe_q[i] <= RST_VAL;
        end else begin
            pipe_q[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
        end
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/regport_ctrl.sv
module regport_ctrl
    import regport_pkg::*;
#(
    parameter int CNT_W = 3,
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  host_cmd_t        cmd_s,
    input  logic [CNT_W-1:0] wait_len,
    input  logic [DW-1:0]    rdata,
    output port_st_e         st,
    output logic             commit_wr,
    output logic             rd_lat,
    output logic [DW-1:0]    rdata_q
);
    port_st_e         st_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] wait_q;
    logic             rd_q;
    logic             finish;

    assign finish = (st_q == ST_BUSY) && (cnt_q == wait_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            cnt_q   <= '0;
            wait_q  <= '0;
            rd_q    <= 1'b0;
            rdata_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (cmd_s.req) begin
                        st_q   <= ST_BUSY;
                        cnt_q  <= CNT_W'(1);
                        wait_q <= wait_len;
                        rd_q   <= cmd_s.rd;
                    end
                end
                ST_BUSY: begin
                    if (finish) begin
                        st_q <= ST_DONE;
                        if (rd_q) rdata_q <= rdata;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                ST_DONE: begin
                    if (!cmd_s.req) st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign st        = st_q;
    assign commit_wr = finish && !rd_q;
    assign rd_lat    = rd_q;
endmodule

// File: rtl/regport_regfile.sv
module regport_regfile #(
    parameter int DW = 8,
    parameter int AW = 3,
    parameter int CTRL_ADDR = 7,
    localparam int DEPTH = 1 << AW
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [AW-1:0]            addr,
    input  logic [DW-1:0]            wdata,
    output logic [DW-1:0]            rdata,
    output logic [1:0]               speed,
    output logic [DEPTH-1:0][DW-1:0] img
);
    logic [DEPTH-1:0][DW-1:0] regs_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                regs_q[g] <= '0;
            else if (we && (addr == AW'(g)))
                regs_q[g] <= wdata;
        end
    end

    assign rdata = regs_q[addr];
    assign speed = regs_q[CTRL_ADDR][1:0];
    assign img   = regs_q;
endmodule

// File: rtl/regport_top.sv
module regport_top
    import regport_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 3,
    parameter int CTRL_ADDR = 7,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W = 3,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_i,
    input  logic          cs_n_i,
    input  logic [AW-1:0] addr_i,
    input  logic          rd_ds_n_i,
    input  logic          wr_rw_i,
    input  logic [DW-1:0] din_i,
    output logic [DW-1:0] dout_o,
    output logic          dout_oe_o,
    output logic          ack_pull_o
);
    logic [2:0]               pins_s;
    host_cmd_t                raw_cmd;
    host_cmd_t                cmd_s;
    port_st_e                 st_w;
    logic                     commit_w;
    logic                     rd_lat_w;
    logic [DW-1:0]            rdata_w;
    logic [1:0]               speed_w;
    logic [DEPTH-1:0][DW-1:0] reg_img;

    regport_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   ({cs_n_i, rd_ds_n_i, wr_rw_i}),
        .q   (pins_s)
    );

    assign raw_cmd = decode_cmd(mode_i, cs_n_i, rd_ds_n_i, wr_rw_i);
    assign cmd_s   = decode_cmd(mode_i, pins_s[2], pins_s[1], pins_s[0]);

    regport_ctrl #(.CNT_W(CNT_W), .DW(DW)) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .cmd_s     (cmd_s),
        .wait_len  (CNT_W'(speed_to_wait(speed_w))),
        .rdata     (rdata_w),
        .st        (st_w),
        .commit_wr (commit_w),
        .rd_lat    (rd_lat_w),
        .rdata_q   (dout_o)
    );

    regport_regfile #(.DW(DW), .AW(AW), .CTRL_ADDR(CTRL_ADDR)) regs_i (
        .clk   (clk),
        .rst   (rst),
        .we    (commit_w),
        .addr  (addr_i),
        .wdata (din_i),
        .rdata (rdata_w),
        .speed (speed_w),
        .img   (reg_img)
    );

    // Mode 0 holds ready low from strobe until completion; mode 1 acknowledges after completion
    assign ack_pull_o = mode_i ? (st_w == ST_DONE)
                               : ((st_w == ST_BUSY) || ((st_w == ST_IDLE) && raw_cmd.req));

    assign dout_oe_o = (st_w == ST_DONE) && rd_lat_w && raw_cmd.req && raw_cmd.rd;
endmodule

// File: rtl/regport_chk.sv
module regport_chk
    import regport_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 3,
    localparam int DEPTH = 1 << AW
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     mode_i,
    input logic                     ack_pull_o,
    input logic                     dout_oe_o,
    input port_st_e                 st,
    input logic                     req_s,
    input logic [1:0]               spd,
    input logic [DEPTH-1:0][DW-1:0] reg_img
);
    logic [3:0] busy_cnt;
    logic [3:0] lat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_cnt <= '0;
            lat_q    <= 4'd2;
        end else begin
            if (st == ST_IDLE) begin
                busy_cnt <= '0;
                lat_q    <= {1'b0, speed_to_wait(spd)};
            end else if (st == ST_BUSY) begin
                busy_cnt <= busy_cnt + 4'd1;
            end
        end
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!ack_pull_o && !dout_oe_o));

    a_r2_ready_low_while_busy: assert property (@(posedge clk) disable iff (rst)
        (!mode_i && st == ST_BUSY) |-> ack_pull_o);

    a_r3_dtack_held_with_strobe: assert property (@(posedge clk) disable iff (rst)
        (mode_i && ack_pull_o && req_s) |=> ack_pull_o);

    a_r4_busy_length: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DONE && $past(st) == ST_BUSY) |-> (busy_cnt == lat_q));

    a_r6_regs_only_on_commit: assert property (@(posedge clk) disable iff (rst)
        (st != ST_BUSY) |=> $stable(reg_img));

    a_r7_data_after_handshake: assert property (@(posedge clk) disable iff (rst)
        dout_oe_o |-> (mode_i ? ack_pull_o : !ack_pull_o));
endmodule

bind regport_top regport_chk #(.DW(DW), .AW(AW)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .mode_i     (mode_i),
    .ack_pull_o (ack_pull_o),
    .dout_oe_o  (dout_oe_o),
    .st         (st_w),
    .req_s      (cmd_s.req),
    .spd        (speed_w),
    .reg_img    (reg_img)
);

// File: tb/regport_top_tb_top.sv
module regport_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       h_mode = 1'b0;
    logic       h_cs_n = 1'b1;
    logic [2:0] h_addr = '0;
    logic       h_a_n = 1'b1;
    logic       h_b = 1'b1;
    logic [7:0] h_din = '0;
    logic [7:0] dout;
    logic       dout_oe;
    logic       ack_pull;

    int checks = 0;
    int errors = 0;
    bit fin = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regport_top dut_i (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (h_mode),
        .cs_n_i     (h_cs_n),
        .addr_i     (h_addr),
        .rd_ds_n_i  (h_a_n),
        .wr_rw_i    (h_b),
        .din_i      (h_din),
        .dout_o     (dout),
        .dout_oe_o  (dout_oe),
        .ack_pull_o (ack_pull)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit h_req();
        if (h_mode) return !h_cs_n && !h_a_n;
        return !h_cs_n && (!h_a_n || !h_b);
    endfunction

    function automatic bit h_read();
        if (h_mode) return h_b;
        return !h_a_n;
    endfunction

    function automatic int spd_wait(input logic [1:0] s);
        if (s == 2'b00) return 2;
        if (s == 2'b01) return 3;
        return 4;
    endfunction

    // Behavioural reference: phase 0 waiting, 1 counting, 2 completed
    int         m_phase, m_age, m_cnt, m_rel, m_wait;
    bit         m_rd;
    logic [7:0] m_regs [8];
    logic [7:0] m_rdq;

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_age = 0; m_cnt = 0; m_rel = 0; m_wait = 2; m_rd = 0; m_rdq = '0;
            foreach (m_regs[i]) m_regs[i] = '0;
        end else begin
            case (m_phase)
                0: begin
                    if (h_req()) begin
                        m_age++;
                        if (m_age == 3) begin
                            m_phase = 1; m_cnt = 0; m_age = 0;
                            m_wait = spd_wait(m_regs[7][1:0]);
                            m_rd = h_read();
                        end
                    end else m_age = 0;
                end
                1: begin
                    m_cnt++;
                    if (m_cnt == m_wait) begin
                        m_phase = 2; m_rel = 0;
                        if (m_rd) m_rdq = m_regs[h_addr];
                        else m_regs[h_addr] = h_din;
                    end
                end
                default: begin
                    if (!h_req()) begin
                        m_rel++;
                        if (m_rel == 3) begin m_phase = 0; m_age = 0; end
                    end else m_rel = 0;
                end
            endcase
        end
    end

    // Per-cycle comparison just before each rising edge
    always @(negedge clk) begin
        #(CLK_PERIOD/2 - 1);
        if (!rst && !fin) begin
            bit exp_pull, exp_oe;
            exp_pull = h_mode ? (m_phase == 2) : (m_phase == 1 || (m_phase == 0 && h_req()));
            exp_oe   = (m_phase == 2) && m_rd && h_req() && h_read();
            chk(ack_pull == exp_pull, h_mode ? "R3 handshake" : "R2 handshake", ack_pull, exp_pull);
            chk(dout_oe == exp_oe, "R7 output enable", dout_oe, exp_oe);
            if (exp_oe) chk(dout == m_rdq, "R6 read data", dout, m_rdq);
        end
    end

    task automatic access(input bit mode, input bit wr, input logic [2:0] addr,
                          input logic [7:0] data, input int hold,
                          output logic [7:0] rdata, output int lat);
        bit seen = 0;
        bit done = 0;
        @(negedge clk);
        h_mode = mode; h_addr = addr; h_din = data; h_cs_n = 1'b0;
        if (mode) begin h_a_n = 1'b0; h_b = !wr; end
        else if (wr) begin h_a_n = 1'b1; h_b = 1'b0; end
        else begin h_a_n = 1'b0; h_b = 1'b1; end
        lat = 0;
        while (!done && lat < 40) begin
            @(posedge clk); #1; lat++;
            if (mode) done = ack_pull;
            else begin
                if (ack_pull) seen = 1;
                else if (seen) done = 1;
            end
        end
        repeat (hold) @(posedge clk);
        @(negedge clk); #1;
        rdata = dout;
        if (hold > 0) chk(ack_pull == mode, "R8 handshake held while strobe held", ack_pull, mode);
        if (!wr) chk(dout_oe == 1'b1, "R7 enable during held read", dout_oe, 1);
        h_a_n = 1'b1; h_b = 1'b1; h_cs_n = 1'b1;
        #1;
        chk(dout_oe == 1'b0, "R7 release on strobe end", dout_oe, 0);
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!fin) begin
            errors++;
            $display("FAIL watchdog R4 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        int lat;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(ack_pull == 0, "R1 handshake idle after reset", ack_pull, 0);
        chk(dout_oe == 0, "R1 bus released after reset", dout_oe, 0);

        access(0, 0, 3'd3, 8'h00, 0, rd, lat);
        chk(rd == 8'h00, "R1 register 3 reset value", rd, 0);
        chk(lat == 5, "R4 fast latency mode 0 read", lat, 5);
        access(0, 0, 3'd7, 8'h00, 0, rd, lat);
        chk(rd == 8'h00, "R1 control register reset value", rd, 0);

        access(0, 1, 3'd1, 8'hA5, 0, rd, lat);
        chk(lat == 5, "R2 ready completes after fast wait", lat, 5);
        access(0, 0, 3'd1, 8'h00, 0, rd, lat);
        chk(rd == 8'hA5, "R6 mode 0 write readback", rd, 8'hA5);

        access(1, 1, 3'd2, 8'h3C, 0, rd, lat);
        chk(lat == 5, "R3 acknowledge after fast wait", lat, 5);
        access(1, 0, 3'd2, 8'h00, 0, rd, lat);
        chk(rd == 8'h3C, "R9 mode 1 write readback", rd, 8'h3C);
        access(1, 0, 3'd1, 8'h00, 0, rd, lat);
        chk(rd == 8'hA5, "R9 cross-mode readback", rd, 8'hA5);

        access(0, 1, 3'd7, 8'h01, 0, rd, lat);
        chk(lat == 5, "R10 speed write uses old setting", lat, 5);
        access(1, 0, 3'd5, 8'h00, 0, rd, lat);
        chk(lat == 6, "R4 medium latency", lat, 6);
        access(1, 1, 3'd7, 8'h02, 0, rd, lat);
        chk(lat == 6, "R10 second speed write uses medium", lat, 6);
        access(0, 0, 3'd5, 8'h00, 0, rd, lat);
        chk(lat == 7, "R4 slow latency", lat, 7);
        access(0, 1, 3'd7, 8'h03, 0, rd, lat);
        access(1, 0, 3'd0, 8'h00, 0, rd, lat);
        chk(lat == 7, "R4 code 11 acts as slow", lat, 7);
        access(1, 1, 3'd7, 8'h00, 0, rd, lat);
        access(0, 0, 3'd7, 8'h00, 0, rd, lat);
        chk(lat == 5, "R10 back to fast", lat, 5);
        chk(rd == 8'h00, "R6 control register readback", rd, 0);

        // R5: strobes without chip select
        @(negedge clk);
        h_mode = 0; h_addr = 3'd1; h_din = 8'hFF; h_cs_n = 1'b1; h_b = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk); #1;
            chk(ack_pull == 0, "R5 no handshake without select", ack_pull, 0);
        end
        h_b = 1'b1; h_mode = 1; h_a_n = 1'b0;
        repeat (8) @(negedge clk);
        h_a_n = 1'b1;
        repeat (4) @(negedge clk);
        access(0, 0, 3'd1, 8'h00, 0, rd, lat);
        chk(rd == 8'hA5, "R5 register untouched without select", rd, 8'hA5);

        // R8: long-held strobes
        access(1, 0, 3'd2, 8'h00, 10, rd, lat);
        chk(rd == 8'h3C, "R8 held mode 1 read data", rd, 8'h3C);
        access(0, 1, 3'd4, 8'h5A, 10, rd, lat);
        access(1, 0, 3'd4, 8'h00, 0, rd, lat);
        chk(rd == 8'h5A, "R8 held write stored once", rd, 8'h5A);

        fin = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule